// File: doc/BRIEF.md
# I2C Target Address Matcher with Broadcast

This block sits behind the bit-level shifter of an I2C target. It receives decoded bus events: start, stop, and each received byte with a one-cycle valid strobe. From these it decides whether the byte should be acknowledged. It answers at two addresses. The first is a local address taken from a 3-bit strap code. The second is a fixed broadcast address, which can be switched off. For each access it reports whether the access is local or broadcast and which direction it runs.

A strap code is sampled only on a rising edge of the shutdown-release input, or when the host sets a re-detect bit. Several targets can be written together through the broadcast address, but acknowledge is meaningless in that case. For this reason every written data byte is folded into a CRC-8. The host then reads the CRC from each target through its local address to confirm that the write arrived intact.

After an address byte, the next write byte is a register pointer; every later write byte is data for that pointer. The pointer does not auto-increment. Pointer 0x02 is the control register: bit 0 enables broadcast matching, and writing 1 to bit 1 requests a re-detect. Writing any data byte to pointer 0x03 clears the checksum.

Top module: `bcast_addr_match`

## Requirements
- R1: The local 8-bit address (R/W as LSB) is 0x70 + 2*code for strap code 0..7, so code 0 gives 0x70 and code 7 gives 0x7E.
- R2: The strap code is captured on a rising edge of shutdownRel, including one seen right after reset. Strap changes at any other time do not alter the address that is matched.
- R3: With broadcast enabled, an address byte of 0x80 (write) is acknowledged and globalAccess goes to 1.
- R4: Broadcast is enabled after reset. Writing a data byte with bit 0 = 0 to pointer 0x02 disables it, after which 0x80 is not acknowledged. Writing bit 0 = 1 re-enables it.
- R5: Writing a data byte with bit 1 = 1 to pointer 0x02 re-captures the current strap code. The request acts once per write.
- R6: A local read (address LSB 1) is acknowledged with readDir = 1. A read to the broadcast address (0x81) is not acknowledged.
- R7: After an address mismatch, no byte is acknowledged and the checksum does not change until the next START or STOP.
- R8: The checksum is CRC-8 (polynomial 0x07, initial 0x00, MSB first) over data bytes only; address and pointer bytes are excluded. It is 0x00 after reset.
- R9: A data byte written to pointer 0x03 sets the checksum to 0x00 instead of folding that byte in.
- R10: ackReq is a one-cycle pulse in the cycle after the rxValid of a matched address byte, a pointer byte or a data byte.
- R11: globalAccess stays at 1 through the data bytes of a broadcast write and is 0 after STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busStart | input | 1 | One-cycle pulse on START or repeated START |
| busStop | input | 1 | One-cycle pulse on STOP |
| rxValid | input | 1 | One-cycle strobe, rxByte holds a received byte |
| rxByte | input | 8 | Received byte |
| strapCode | input | 3 | Level code of the address strap |
| shutdownRel | input | 1 | High while the device is out of shutdown |
| ackReq | output | 1 | Acknowledge request for the byte just received |
| globalAccess | output | 1 | Current access uses the broadcast address |
| readDir | output | 1 | Current access is a read |
| cksum | output | 8 | Running CRC-8 of written data bytes |

## Verification
The assertions take for granted that rxValid, busStart and busStop are single-cycle pulses, and that no two of them arrive in the same cycle. The ack-pulse and stop checks rest on that. The bench drives each event in its own cycle, one cycle apart, and it changes the strap code only while shutdownRel is steady or low. No capture edge therefore coincides with a byte.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_DATA, ST_READ, ST_SKIP
  } busState_t;

  typedef struct packed {
    logic capStrap;
    logic ldPtr;
    logic wrData;
  } dpStrobe_t;

  function automatic logic [7:0] crcStep(input logic [7:0] crcIn,
                                         input logic [7:0] din,
                                         input logic [7:0] poly);
    logic [7:0] acc;
    acc = crcIn ^ din;
    for (int i = 0; i < 8; i++) begin
      acc = acc[7] ? ((acc << 1) ^ poly) : (acc << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/bam_ctrl.sv
module bam_ctrl
  import bam_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] GLOBAL_ADDR = 7'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              shutdownRel,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic              globalEn,
  output dpStrobe_t         strobe,
  output logic              ackReq,
  output logic              globalAccess,
  output logic              readDir
);
  busState_t state;
  logic shdnPrev;
  logic localHit, globalHit, isRead;

  always_comb begin
    localHit  = rxByte[7:1] == localAddr;
    globalHit = globalEn && (rxByte[7:1] == GLOBAL_ADDR);
    isRead    = rxByte[0];
    strobe.capStrap = shutdownRel && !shdnPrev;
    strobe.ldPtr    = rxValid && !busStart && !busStop && state == ST_PTR;
    strobe.wrData   = rxValid && !busStart && !busStop && state == ST_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      shdnPrev     <= 1'b0;
      ackReq       <= 1'b0;
      globalAccess <= 1'b0;
      readDir      <= 1'b0;
    end else begin
      shdnPrev <= shutdownRel;
      ackReq   <= 1'b0;
      if (busStop) begin
        state        <= ST_IDLE;
        globalAccess <= 1'b0;
        readDir      <= 1'b0;
      end else if (busStart) begin
        state <= ST_ADDR;
      end else if (rxValid) begin
        unique case (state)
          ST_ADDR: begin
            if (localHit) begin
              ackReq       <= 1'b1;
              globalAccess <= 1'b0;
              readDir      <= isRead;
              state        <= isRead ? ST_READ : ST_PTR;
            end else if (globalHit && !isRead) begin
              ackReq       <= 1'b1;
              globalAccess <= 1'b1;
              readDir      <= 1'b0;
              state        <= ST_PTR;
            end else begin
              globalAccess <= 1'b0;
              readDir      <= 1'b0;
              state        <= ST_SKIP;
            end
          end
          ST_PTR: begin
            ackReq <= 1'b1;
            state  <= ST_DATA;
          end
          ST_DATA: ackReq <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R10
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackReq |-> $past(rxValid));
  // R7
  skip_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP && !busStart && !busStop) |=> !ackReq);
  // R11
  stop_clears_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busStop |=> !globalAccess);
  // R6
  no_global_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(globalAccess && readDir));
endmodule

// File: rtl/bam_datapath.sv
module bam_datapath
  import bam_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-1:0] LOCAL_BASE = 7'h38,
  parameter logic [7:0] CTRL_PTR = 8'h02,
  parameter logic [7:0] CKSUM_PTR = 8'h03,
  parameter logic [7:0] CRC_POLY = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobe_t          strobe,
  input  logic [7:0]         rxByte,
  input  logic [STRAP_W-1:0] strapCode,
  output logic [ADDR_W-1:0]  localAddr,
  output logic               globalEn,
  output logic [7:0]         cksum
);
  localparam int PAD_W = ADDR_W - STRAP_W;

  logic [7:0] ptrReg;
  logic ctrlWr, redetect, capture;

  always_comb begin
    ctrlWr   = strobe.wrData && ptrReg == CTRL_PTR;
    redetect = ctrlWr && rxByte[1];
    capture  = strobe.capStrap || redetect;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrReg    <= '0;
      localAddr <= LOCAL_BASE;
      globalEn  <= 1'b1;
      cksum     <= '0;
    end else begin
      if (strobe.ldPtr) ptrReg <= rxByte;
      if (capture) localAddr <= LOCAL_BASE + {{PAD_W{1'b0}}, strapCode};
      if (ctrlWr) globalEn <= rxByte[0];
      if (strobe.wrData)
        cksum <= (ptrReg == CKSUM_PTR) ? 8'h00 : crcStep(cksum, rxByte, CRC_POLY);
    end
  end

  // R8
  cksum_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrData |=> $stable(cksum));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.capStrap && !strobe.wrData) |=> $stable(localAddr));
endmodule

// File: rtl/bcast_addr_match.sv
module bcast_addr_match
  import bam_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busStart,
  input  logic               busStop,
  input  logic               rxValid,
  input  logic [7:0]         rxByte,
  input  logic [STRAP_W-1:0] strapCode,
  input  logic               shutdownRel,
  output logic               ackReq,
  output logic               globalAccess,
  output logic               readDir,
  output logic [7:0]         cksum
);
  dpStrobe_t strobe;
  logic [ADDR_W-1:0] localAddr;
  logic globalEn;

  bam_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busStart(busStart), .busStop(busStop),
    .rxValid(rxValid), .rxByte(rxByte), .shutdownRel(shutdownRel),
    .localAddr(localAddr), .globalEn(globalEn), .strobe(strobe),
    .ackReq(ackReq), .globalAccess(globalAccess), .readDir(readDir)
  );

  bam_datapath #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rxByte(rxByte),
    .strapCode(strapCode), .localAddr(localAddr), .globalEn(globalEn),
    .cksum(cksum)
  );
endmodule

// File: tb/bcast_addr_match_tb.sv
module bcast_addr_match_tb_top;
  logic clk = 0, rst_n = 0;
  logic busStart = 0, busStop = 0, rxValid = 0, shutdownRel = 0;
  logic [7:0] rxByte = 0;
  logic [2:0] strapCode = 0;
  logic ackReq, globalAccess, readDir;
  logic [7:0] cksum;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  bcast_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .busStart(busStart), .busStop(busStop),
    .rxValid(rxValid), .rxByte(rxByte), .strapCode(strapCode),
    .shutdownRel(shutdownRel), .ackReq(ackReq), .globalAccess(globalAccess),
    .readDir(readDir), .cksum(cksum)
  );

  // {addrByte, expAck, expGlobal, expRead}, local address 0x7A
  localparam logic [10:0] VEC [8] = '{
    {8'h7A, 3'b100}, {8'h7B, 3'b101}, {8'h80, 3'b110}, {8'h81, 3'b000},
    {8'h70, 3'b000}, {8'h7E, 3'b000}, {8'h7C, 3'b000}, {8'h00, 3'b000}
  };

  function automatic logic [7:0] refCrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startEv();
    @(negedge clk) busStart = 1;
    @(negedge clk) busStart = 0;
  endtask

  task automatic stopEv();
    @(negedge clk) busStop = 1;
    @(negedge clk) busStop = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    @(negedge clk) begin rxByte = b; rxValid = 1; end
    @(negedge clk) rxValid = 0;
    ack = ackReq;
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic [7:0] ptr, input logic [7:0] val);
    logic a;
    startEv(); sendByte(addr, a); sendByte(ptr, a); sendByte(val, a); stopEv();
  endtask

  task automatic probe(input logic [7:0] addr, output logic ack);
    startEv(); sendByte(addr, ack); stopEv();
  endtask

  task automatic powerCycle(input logic [2:0] code);
    @(negedge clk) shutdownRel = 0;
    @(negedge clk) strapCode = code;
    @(negedge clk) shutdownRel = 1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset cksum", cksum, 8'h00);
    chk("R10 reset ack", ackReq, 0);
    chk("R11 reset global", globalAccess, 0);
    rst_n = 1;
    strapCode = 3'd5;
    @(negedge clk) shutdownRel = 1;
    @(negedge clk);

    // R1 R3 R6 vector walk
    for (int i = 0; i < 8; i++) begin
      startEv();
      sendByte(VEC[i][10:3], a);
      chk("R1/R3/R6 ack", a, VEC[i][2]);
      chk("R3 global", globalAccess, VEC[i][1]);
      if (VEC[i][2]) chk("R6 dir", readDir, VEC[i][0]);
      stopEv();
    end

    // R10 pulse width
    startEv(); sendByte(8'h7A, a);
    @(negedge clk) chk("R10 one cycle", ackReq, 0);
    stopEv();

    // R2 strap change without edge ignored
    strapCode = 3'd2;
    probe(8'h74, a); chk("R2 no recapture", a, 0);
    probe(8'h7A, a); chk("R2 held", a, 1);

    // R5 re-detect via control register
    writeReg(8'h7A, 8'h02, 8'h03);
    probe(8'h74, a); chk("R5 redetect new", a, 1);
    probe(8'h7A, a); chk("R5 redetect old", a, 0);
    strapCode = 3'd6;
    probe(8'h74, a); chk("R5 acts once", a, 1);

    // R9 clear checksum
    writeReg(8'h74, 8'h03, 8'h99);
    chk("R9 clear", cksum, 8'h00);

    // R8 R11 broadcast write with CRC
    startEv(); sendByte(8'h80, a); sendByte(8'h10, a);
    chk("R8 ptr excluded", cksum, 8'h00);
    sendByte(8'hA5, a);
    chk("R11 global held", globalAccess, 1);
    chk("R10 data ack", a, 1);
    sendByte(8'h3C, a);
    exp = refCrc(refCrc(8'h00, 8'hA5), 8'h3C);
    chk("R8 crc", cksum, exp);
    stopEv();
    chk("R11 stop clears", globalAccess, 0);

    // R7 mismatch ignores bytes
    startEv(); sendByte(8'h90, a); chk("R7 addr", a, 0);
    sendByte(8'h10, a); chk("R7 ptr", a, 0);
    sendByte(8'h55, a); chk("R7 data", a, 0);
    chk("R7 cksum", cksum, exp);
    stopEv();

    // R4 disable and re-enable broadcast
    writeReg(8'h74, 8'h02, 8'h00);
    probe(8'h80, a); chk("R4 disabled", a, 0);
    writeReg(8'h74, 8'h02, 8'h01);
    probe(8'h80, a); chk("R4 enabled", a, 1);

    // R1 R2 every strap code via shutdown release
    for (int k = 0; k < 8; k++) begin
      powerCycle(k[2:0]);
      probe(8'h70 + 8'(2 * k), a); chk("R1 code match", a, 1);
      probe(8'h70 + 8'(2 * ((k + 1) % 8)), a); chk("R1 other code", a, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule